// File: doc/BRIEF.md
# Two-Wire Bus Role and Address Controller

This block keeps the role state of a two-wire serial bus controller: whether the device drives the bus as master or answers as slave, whether it currently sends or receives, the seven-bit address it answers to, and whether address recognition is used at all. Software writes these fields directly. The bus engine reports events as one-cycle strobes: start seen, byte completed, acknowledge sampled, stop seen and arbitration lost. From these strobes the block moves the flags on by itself.

After the address phase the direction flag follows the read/write bit, but with opposite sense depending on role. A slave that recognises its own address becomes a transmitter when the master asks to read. A master whose address byte is acknowledged becomes a receiver when it asked to read. In free-data mode no address is recognised, and every byte from the start condition on is reported as plain data. The bus engine uses `addrMatch` to decide whether to acknowledge, and `dataByte` to hand bytes to the data path.

Top module: `i2cRoleCtl`

## Requirements
- R1: After reset, `isMaster`, `isXmit`, `ownAddr`, `freeMode`, `addrMatch` and `dataByte` are all 0.
- R2: A pulse on `addrWrEn` loads `ownAddr` from `addrWrData[7:1]` and `freeMode` from `addrWrData[0]`. A pulse on `roleWrEn` loads `isMaster` from `roleWrData[1]` (1 = master) and `isXmit` from `roleWrData[0]` (1 = transmitter). Both are visible one cycle later.
- R3: `stopDet` or `arbLost` clears `isMaster` on the next cycle.
- R4: `addrMatch` is high for exactly one cycle: the cycle after a `byteDone` for the first byte after `startDet`. This happens only while the block is a slave, `freeMode` is 0 and `byteIn[7:1]` equals `ownAddr`.
- R5: On an address match, `isXmit` takes the value of the read/write bit `byteIn[0]` in the same cycle that `addrMatch` is high.
- R6: A slave address byte that does not match leaves `isXmit` unchanged and gives no `addrMatch`.
- R7: As master, the address byte is the first byte after start, and its read/write bit is `byteIn[0]`. When `ackSampled` comes with `ackOk` = 1 after that byte, `isXmit` becomes the inverse of that bit on the next cycle.
- R8: As master, `ackSampled` with `ackOk` = 0 after the address byte leaves `isXmit` unchanged.
- R9: With `freeMode` = 1, every completed byte, the first one after start included, pulses `dataByte` for one cycle. `addrMatch` stays 0 and `isXmit` is not changed by bus events.
- R10: With `freeMode` = 0, the address byte gives no `dataByte`. Each later byte gives a one-cycle `dataByte` in the cycle after its `byteDone`, and `addrMatch` and `dataByte` are never high together.
- R11: A software write to the role fields in the same cycle as a hardware update wins: the written value is what appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addrWrEn | input | 1 | Write strobe for the address field |
| addrWrData | input | 8 | Own address in [7:1], free-data select in [0] |
| roleWrEn | input | 1 | Write strobe for the role field |
| roleWrData | input | 2 | [1] master, [0] transmitter |
| startDet | input | 1 | Start condition seen |
| byteDone | input | 1 | A byte finished on the bus |
| byteIn | input | 8 | The byte just finished |
| ackSampled | input | 1 | Acknowledge slot sampled |
| ackOk | input | 1 | 1 when the acknowledge was given |
| stopDet | input | 1 | Stop condition seen |
| arbLost | input | 1 | Arbitration lost |
| isMaster | output | 1 | Current role, 1 = master |
| isXmit | output | 1 | Current direction, 1 = transmitter |
| ownAddr | output | 7 | Own slave address |
| freeMode | output | 1 | 1 = free-data mode |
| addrMatch | output | 1 | One-cycle pulse on own-address recognition |
| dataByte | output | 1 | One-cycle pulse marking a plain data byte |

## Verification
A corrupt first-byte tracker shows on the next completed byte. That byte either raises `addrMatch` where `dataByte` was due, or the reverse, one cycle after `byteDone`. A lost pending-acknowledge state in master mode leaves `isXmit` stale one cycle after the acknowledge strobe. A wrong direction rule inverts `isXmit` in the same cycle that `addrMatch` pulses. Wrong priority between software and hardware is seen one cycle after the colliding write, because the written role bits do not appear.

// File: rtl/i2cRolePkg.sv
package i2cRolePkg;
  typedef struct packed {
    logic clrMaster;
    logic setXmit;
    logic clrXmit;
  } hwStrobes_t;
endpackage

// File: rtl/i2cRoleCtrl.sv
module i2cRoleCtrl
  import i2cRolePkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startDet,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              ackSampled,
  input  logic              ackOk,
  input  logic              stopDet,
  input  logic              arbLost,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              freeMode,
  input  logic              isMaster,
  output hwStrobes_t        hw,
  output logic              matchPulse,
  output logic              dataPulse
);
  logic firstByte;
  logic ackPend;
  logic rwLat;
  logic addrPhase;
  logic matchNow;
  logic dataNow;
  logic ackHit;

  // the first byte after start is an address byte unless in free mode
  assign addrPhase = byteDone && firstByte && !freeMode;
  assign matchNow  = addrPhase && !isMaster && (byteIn[BYTE_W-1:1] == ownAddr);
  assign dataNow   = byteDone && !(firstByte && !freeMode);
  assign ackHit    = ackSampled && ackPend && ackOk;

  always_comb begin
    hw.clrMaster = stopDet || arbLost;
    hw.setXmit   = (matchNow && byteIn[0]) || (ackHit && !rwLat);
    hw.clrXmit   = (matchNow && !byteIn[0]) || (ackHit && rwLat);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      firstByte  <= 1'b0;
      ackPend    <= 1'b0;
      rwLat      <= 1'b0;
      matchPulse <= 1'b0;
      dataPulse  <= 1'b0;
    end else begin
      matchPulse <= matchNow;
      dataPulse  <= dataNow;
      if (startDet)                     firstByte <= 1'b1;
      else if (byteDone || stopDet)     firstByte <= 1'b0;
      if (startDet || stopDet) begin
        ackPend <= 1'b0;
      end else if (addrPhase && isMaster) begin
        ackPend <= 1'b1;
        rwLat   <= byteIn[0];
      end else if (ackSampled) begin
        ackPend <= 1'b0;
      end
    end
  end

  // R4: match is a single-cycle pulse
  p_match_single_r4: assert property (@(posedge clk) disable iff (rst)
    matchPulse |=> !matchPulse);
  // R4, R9: match only as slave in addressing mode
  p_match_qual_r9: assert property (@(posedge clk) disable iff (rst)
    matchPulse |-> $past(!freeMode && !isMaster && byteDone));
  // R10: match and data marker exclusive
  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(matchPulse && dataPulse));
endmodule

// File: rtl/i2cRoleRegs.sv
module i2cRoleRegs
  import i2cRolePkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addrWrEn,
  input  logic [BYTE_W-1:0] addrWrData,
  input  logic              roleWrEn,
  input  logic [1:0]        roleWrData,
  input  hwStrobes_t        hw,
  output logic [ADDR_W-1:0] ownAddr,
  output logic              freeMode,
  output logic              isMaster,
  output logic              isXmit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ownAddr  <= '0;
      freeMode <= 1'b0;
      isMaster <= 1'b0;
      isXmit   <= 1'b0;
    end else begin
      if (addrWrEn) begin
        ownAddr  <= addrWrData[BYTE_W-1:1];
        freeMode <= addrWrData[0];
      end
      // software write overrides any same-cycle hardware update
      if (roleWrEn) begin
        isMaster <= roleWrData[1];
        isXmit   <= roleWrData[0];
      end else begin
        if (hw.clrMaster) isMaster <= 1'b0;
        if (hw.setXmit)       isXmit <= 1'b1;
        else if (hw.clrXmit)  isXmit <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2cRoleCtl.sv
module i2cRoleCtl
  import i2cRolePkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addrWrEn,
  input  logic [BYTE_W-1:0] addrWrData,
  input  logic              roleWrEn,
  input  logic [1:0]        roleWrData,
  input  logic              startDet,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              ackSampled,
  input  logic              ackOk,
  input  logic              stopDet,
  input  logic              arbLost,
  output logic              isMaster,
  output logic              isXmit,
  output logic [ADDR_W-1:0] ownAddr,
  output logic              freeMode,
  output logic              addrMatch,
  output logic              dataByte
);
  hwStrobes_t hw;

  i2cRoleCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .startDet(startDet), .byteDone(byteDone),
    .byteIn(byteIn), .ackSampled(ackSampled), .ackOk(ackOk),
    .stopDet(stopDet), .arbLost(arbLost), .ownAddr(ownAddr),
    .freeMode(freeMode), .isMaster(isMaster), .hw(hw),
    .matchPulse(addrMatch), .dataPulse(dataByte)
  );

  i2cRoleRegs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addrWrEn(addrWrEn), .addrWrData(addrWrData),
    .roleWrEn(roleWrEn), .roleWrData(roleWrData), .hw(hw),
    .ownAddr(ownAddr), .freeMode(freeMode), .isMaster(isMaster),
    .isXmit(isXmit)
  );

  // R3: stop or lost arbitration drops master role
  p_drop_master_r3: assert property (@(posedge clk) disable iff (rst)
    (stopDet || arbLost) && !roleWrEn |=> !isMaster);
  // R5: slave direction follows the received read/write bit
  p_slave_dir_r5: assert property (@(posedge clk) disable iff (rst)
    addrMatch && !$past(roleWrEn) |-> isXmit == $past(byteIn[0]));
  // R11: software role write is what appears
  p_sw_wins_r11: assert property (@(posedge clk) disable iff (rst)
    roleWrEn |=> {isMaster, isXmit} == $past(roleWrData));
endmodule

// File: tb/i2cRoleCtl_tb.sv
module i2cRoleCtl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addrWrEn = 0, roleWrEn = 0, startDet = 0, byteDone = 0;
  logic ackSampled = 0, ackOk = 0, stopDet = 0, arbLost = 0;
  logic [7:0] addrWrData = '0, byteIn = '0;
  logic [1:0] roleWrData = '0;
  logic isMaster, isXmit, freeMode, addrMatch, dataByte;
  logic [6:0] ownAddr;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  i2cRoleCtl u_dut (
    .clk(clk), .rst(rst), .addrWrEn(addrWrEn), .addrWrData(addrWrData),
    .roleWrEn(roleWrEn), .roleWrData(roleWrData), .startDet(startDet),
    .byteDone(byteDone), .byteIn(byteIn), .ackSampled(ackSampled),
    .ackOk(ackOk), .stopDet(stopDet), .arbLost(arbLost),
    .isMaster(isMaster), .isXmit(isXmit), .ownAddr(ownAddr),
    .freeMode(freeMode), .addrMatch(addrMatch), .dataByte(dataByte)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    {addrWrEn, roleWrEn, startDet, byteDone, ackSampled, stopDet, arbLost} = '0;
  endtask

  task automatic wrAddr(input logic [7:0] v);
    @(negedge clk); addrWrEn = 1; addrWrData = v; idle();
  endtask

  task automatic wrRole(input logic [1:0] v);
    @(negedge clk); roleWrEn = 1; roleWrData = v; idle();
  endtask

  task automatic start();
    @(negedge clk); startDet = 1; idle();
  endtask

  task automatic stop();
    @(negedge clk); stopDet = 1; idle();
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expM, input logic expD, input string tag);
    @(negedge clk); byteDone = 1; byteIn = b; idle();
    chk(addrMatch, expM, {tag, " match"});
    chk(dataByte, expD, {tag, " data"});
  endtask

  task automatic ack(input logic ok);
    @(negedge clk); ackSampled = 1; ackOk = ok; idle();
  endtask

  task automatic testReset();
    chk({isMaster, isXmit, freeMode, addrMatch, dataByte}, 0, "R1 flags");
    chk(ownAddr, 0, "R1 addr");
  endtask

  task automatic testWrites();
    wrAddr(8'hA4);
    chk(ownAddr, 7'h52, "R2 addr");
    chk(freeMode, 0, "R2 free");
    wrRole(2'b10);
    chk({isMaster, isXmit}, 2'b10, "R2 role");
    wrRole(2'b00);
    chk({isMaster, isXmit}, 2'b00, "R2 role clear");
  endtask

  task automatic testSlave();
    start();
    sendByte({7'h52, 1'b1}, 1, 0, "R4 slave read");
    chk(isXmit, 1, "R5 read sets xmit");
    idle();
    chk(addrMatch, 0, "R4 single cycle");
    sendByte(8'h33, 0, 1, "R10 data after addr");
    idle();
    chk(dataByte, 0, "R10 data single cycle");
    stop();
    start();
    sendByte({7'h11, 1'b0}, 0, 0, "R6 no match");
    chk(isXmit, 1, "R6 xmit kept");
    start();
    sendByte({7'h52, 1'b0}, 1, 0, "R4 slave write");
    chk(isXmit, 0, "R5 write clears xmit");
    stop();
  endtask

  task automatic testMaster();
    wrRole(2'b11);
    start();
    sendByte({7'h52, 1'b1}, 0, 0, "R4 no match as master");
    chk(isXmit, 1, "R7 before ack");
    ack(1);
    chk(isXmit, 0, "R7 read acked -> rx");
    start();
    sendByte({7'h20, 1'b0}, 0, 0, "R7 addr");
    ack(1);
    chk(isXmit, 1, "R7 write acked -> tx");
    start();
    sendByte({7'h20, 1'b1}, 0, 0, "R8 addr");
    ack(0);
    chk(isXmit, 1, "R8 no ack keeps");
    stop();
    chk(isMaster, 0, "R3 stop clears master");
    wrRole(2'b11);
    @(negedge clk); arbLost = 1; idle();
    chk(isMaster, 0, "R3 arb lost clears master");
  endtask

  task automatic testFree();
    wrAddr(8'hA5);
    chk(freeMode, 1, "R9 free set");
    wrRole(2'b00);
    start();
    sendByte(8'hA5, 0, 1, "R9 first byte data");
    chk(isXmit, 0, "R9 xmit untouched");
    sendByte(8'hA4, 0, 1, "R9 second byte");
    stop();
  endtask

  task automatic testPriority();
    wrAddr(8'hA4);
    wrRole(2'b10);
    @(negedge clk); roleWrEn = 1; roleWrData = 2'b10; stopDet = 1; idle();
    chk(isMaster, 1, "R11 write beats stop");
    wrRole(2'b00);
    start();
    @(negedge clk); byteDone = 1; byteIn = {7'h52, 1'b1}; roleWrEn = 1; roleWrData = 2'b00; idle();
    chk(addrMatch, 1, "R11 match still pulses");
    chk(isXmit, 0, "R11 write beats direction update");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    testReset();
    testWrites();
    testSlave();
    testMaster();
    testFree();
    testPriority();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule